// File: doc/BRIEF.md
# BCH Sector Bit Corrector

This block applies the error corrections that a BCH error-location search has found for one 512-byte sector held in an attached byte-wide buffer. Every reported bit location is checked against the parity region for the chosen code strength. Locations in the parity region, or beyond the end of the sector, are dropped. Each data location is turned into a byte address and a single-bit mask, with the sector's bit order reversed. The byte is then corrected by a read, an XOR and a write-back.

Two side functions sit next to the corrector. A combinational path reverses the byte order of the computed syndrome and appends a 0xFF terminator, so the syndrome arrives at the decoder in the order it expects. An erased-page detector checks the stored parity bytes. If they are all 0xFF, the operation ends at once with success and the buffer is left alone. An uncorrectable flag from the decoder ends the operation with an error status, and the buffer is not modified.

Top module: `bch_bitfix`

## Requirements
- R1: `mode_i` selects the code strength: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, and 3 behaves as 8-bit. The parity region is 52, 104 or 208 bits long. A location below that length is ignored and causes no buffer access.
- R2: For a location L at or above the parity length P, the data index is d = L − P. The byte corrected is at address 511 − floor(d/8), with mask 1 << (d mod 8).
- R3: A location with d ≥ 4096 lies outside the sector and is ignored.
- R4: Each correction reads the byte at `buf_addr_o` with `buf_rd_o`. The read data arrives on `buf_rdata_i` one cycle later. In that next cycle the block asserts `buf_wr_o` at the same address, with `buf_wdata_o` = read data XOR mask. Read and write are never asserted in the same cycle.
- R5: `syn_o` byte i equals `calc_i` byte n−1−i for i < n, where n is 8, 13 or 28 for modes 0, 1 and 2 (and 13 for mode 3). Byte n is 0xFF and the higher bytes are 0x00.
- R6: When the first n bytes of `par_i` are all 0xFF at start, `done_o` rises on the next cycle with `err_o` = 0 and no buffer access. Bytes above n do not matter. This check takes priority over `uncorr_i`.
- R7: When `uncorr_i` is high at start and the page is not erased, `done_o` rises on the next cycle with `err_o` = 1 and no buffer access.
- R8: The first min(`err_cnt_i`, 8) locations are processed in order. A count of 0 finishes with no access. Repeated locations flip the same bit again.
- R9: `done_o` is a one-cycle pulse. Counting edges from the edge that samples start to the first edge at which `done_o` is high, it comes 2 + 2·V + I edges later for V applied and I ignored locations, and 1 edge later on the immediate paths. Start is ignored while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Code strength select |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| uncorr_i | input | 1 | Decoder reports uncorrectable sector |
| err_cnt_i | input | 4 | Number of reported locations |
| err_loc_i | input | 104 | Eight 13-bit locations, entry k at bits [13k+12:13k] |
| par_i | input | 224 | Stored parity bytes, byte k at bits [8k+7:8k] |
| calc_i | input | 224 | Computed syndrome bytes, byte k at bits [8k+7:8k] |
| syn_o | output | 232 | Reversed syndrome with terminator |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Status of the last operation, 1 = uncorrectable |

## Verification
The hardest situation to reach is a single run that mixes ignored and applied locations, with repeats landing on the same byte. Here a write-back must be visible to the very next read, and the latency depends on how the locations split between the two kinds. The bench reaches it with location sets aimed at each parity edge and sector edge in every mode, plus a long pseudo-random sweep whose locations are bounded close to the mapped range so that collisions are frequent. A second start pulse injected mid-operation shows that a busy block ignores it.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

  typedef enum logic [1:0] {
    MODE_T4  = 2'd0,
    MODE_T8  = 2'd1,
    MODE_T16 = 2'd2,
    MODE_RSV = 2'd3
  } bch_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } fix_state_e;

  // parity region length in bits (nibbles times four)
  function automatic int unsigned parity_bits(bch_mode_e m);
    case (m)
      MODE_T4:  return 52;
      MODE_T16: return 208;
      default:  return 104;
    endcase
  endfunction

  // syndrome byte count handed to the decoder
  function automatic int unsigned syn_bytes(bch_mode_e m);
    case (m)
      MODE_T4:  return 8;
      MODE_T16: return 28;
      default:  return 13;
    endcase
  endfunction

endpackage

// File: rtl/bchfix_locmap.sv
module bchfix_locmap
  import bchfix_pkg::*;
#(
  parameter int LOC_W      = 13,
  parameter int SECT_BYTES = 512
) (
  input  bch_mode_e               mode,
  input  logic [LOC_W-1:0]        loc,
  output logic                    hit,
  output logic [$clog2(SECT_BYTES)-1:0] addr,
  output logic [7:0]              mask
);
  localparam int ADDR_W    = $clog2(SECT_BYTES);
  localparam int SECT_BITS = SECT_BYTES * 8;

  logic [LOC_W-1:0] plen;
  logic [LOC_W-1:0] dbit;
  logic [LOC_W-1:0] rev;

  always_comb begin
    plen = LOC_W'(parity_bits(mode));
    dbit = loc - plen;
    hit  = (loc >= plen) && (dbit < LOC_W'(SECT_BITS));
    rev  = LOC_W'(SECT_BITS - 1) - dbit;
    addr = rev[3 +: ADDR_W];
    mask = 8'h01 << dbit[2:0];
  end

endmodule

// File: rtl/bchfix_synrev.sv
module bchfix_synrev
  import bchfix_pkg::*;
#(
  parameter int MAX_SYN = 28
) (
  input  bch_mode_e                 mode,
  input  logic [MAX_SYN*8-1:0]      calc,
  output logic [(MAX_SYN+1)*8-1:0]  syn
);
  int unsigned n;
  always_comb n = syn_bytes(mode);

  for (genvar i = 0; i <= MAX_SYN; i++) begin : g_byte
    int unsigned src;
    always_comb begin
      src = (i < n) ? (n - 1 - i) : 0;
      if (i < n)       syn[i*8 +: 8] = calc[src*8 +: 8];
      else if (i == n) syn[i*8 +: 8] = 8'hFF;
      else             syn[i*8 +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/bchfix_erasechk.sv
module bchfix_erasechk
  import bchfix_pkg::*;
#(
  parameter int MAX_SYN = 28
) (
  input  bch_mode_e             mode,
  input  logic [MAX_SYN*8-1:0]  par,
  output logic                  erased
);
  logic [MAX_SYN-1:0] ok;
  int unsigned n;
  always_comb n = syn_bytes(mode);

  for (genvar i = 0; i < MAX_SYN; i++) begin : g_chk
    always_comb ok[i] = (par[i*8 +: 8] == 8'hFF) || (i >= n);
  end

  always_comb erased = &ok;

endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix
  import bchfix_pkg::*;
#(
  parameter int MAX_ERR    = 8,
  parameter int LOC_W      = 13,
  parameter int SECT_BYTES = 512,
  parameter int MAX_SYN    = 28,
  localparam int CNT_W     = $clog2(MAX_ERR + 1),
  localparam int ADDR_W    = $clog2(SECT_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_i,
  input  logic                       start_i,
  input  logic                       uncorr_i,
  input  logic [CNT_W-1:0]           err_cnt_i,
  input  logic [MAX_ERR*LOC_W-1:0]   err_loc_i,
  input  logic [MAX_SYN*8-1:0]       par_i,
  input  logic [MAX_SYN*8-1:0]       calc_i,
  output logic [(MAX_SYN+1)*8-1:0]   syn_o,
  output logic [ADDR_W-1:0]          buf_addr_o,
  output logic                       buf_rd_o,
  input  logic [7:0]                 buf_rdata_i,
  output logic                       buf_wr_o,
  output logic [7:0]                 buf_wdata_o,
  output logic                       done_o,
  output logic                       err_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  bch_mode_e mode_live;
  always_comb mode_live = bch_mode_e'(mode_i);

  bchfix_synrev #(.MAX_SYN(MAX_SYN)) synrev_i (
    .mode (mode_live),
    .calc (calc_i),
    .syn  (syn_o)
  );

  logic erased;
  bchfix_erasechk #(.MAX_SYN(MAX_SYN)) erasechk_i (
    .mode   (mode_live),
    .par    (par_i),
    .erased (erased)
  );

  fix_state_e                 state_q, state_d;
  logic [CNT_W-1:0]           idx_q, idx_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  bch_mode_e                  mode_q, mode_d;
  logic [MAX_ERR*LOC_W-1:0]   locs_q, locs_d;
  logic                       err_q, err_d;
  logic                       cap_en;

  logic [LOC_W-1:0] cur_loc;
  logic             hit;
  logic [ADDR_W-1:0] map_addr;
  logic [7:0]       map_mask;

  always_comb begin
    cur_loc = '0;
    for (int k = 0; k < MAX_ERR; k++)
      if (idx_q == CNT_W'(k)) cur_loc = locs_q[k*LOC_W +: LOC_W];
  end

  bchfix_locmap #(.LOC_W(LOC_W), .SECT_BYTES(SECT_BYTES)) locmap_i (
    .mode (mode_q),
    .loc  (cur_loc),
    .hit  (hit),
    .addr (map_addr),
    .mask (map_mask)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    locs_d   = locs_q;
    err_d    = err_q;
    cap_en   = 1'b0;
    buf_rd_o = 1'b0;
    buf_wr_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          mode_d = mode_live;
          locs_d = err_loc_i;
          cnt_d  = (err_cnt_i > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_cnt_i;
          idx_d  = '0;
          if (erased) begin
            err_d   = 1'b0;
            state_d = ST_DONE;
          end else if (uncorr_i) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            err_d   = 1'b0;
            state_d = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        if (idx_q >= cnt_q) begin
          state_d = ST_DONE;
        end else if (hit) begin
          buf_rd_o = 1'b1;
          state_d  = ST_WRITE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WRITE: begin
        buf_wr_o = 1'b1;
        idx_d    = idx_q + 1'b1;
        state_d  = ST_STEP;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    buf_addr_o  = map_addr;
    buf_wdata_o = buf_rdata_i ^ map_mask;
    done_o      = (state_q == ST_DONE);
    err_o       = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cnt_q  <= '0;
      mode_q <= MODE_T8;
      locs_q <= '0;
    end else if (cap_en) begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      locs_q <= locs_d;
    end
  end

  // checks beside the logic they guard
  assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !(buf_rd_o && buf_wr_o));

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_q)
    buf_rd_o |=> (buf_wr_o && $stable(buf_addr_o)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o);

  assert_erased_skip_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_IDLE && start_i && erased) |=> (done_o && !err_o));

  assert_abort_uncorr_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_IDLE && start_i && !erased && uncorr_i) |=> (done_o && err_o));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_IDLE) |-> (!buf_rd_o && !buf_wr_o));

endmodule

// File: tb/bch_bitfix_tb_top.sv
module bch_bitfix_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_i;
  logic         start_i, uncorr_i;
  logic [3:0]   err_cnt_i;
  logic [103:0] err_loc_i;
  logic [223:0] par_i, calc_i;
  logic [231:0] syn_o;
  logic [8:0]   buf_addr_o;
  logic         buf_rd_o, buf_wr_o, done_o, err_o;
  logic [7:0]   buf_rdata_i, buf_wdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_bitfix dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
    .uncorr_i(uncorr_i), .err_cnt_i(err_cnt_i), .err_loc_i(err_loc_i),
    .par_i(par_i), .calc_i(calc_i), .syn_o(syn_o),
    .buf_addr_o(buf_addr_o), .buf_rd_o(buf_rd_o), .buf_rdata_i(buf_rdata_i),
    .buf_wr_o(buf_wr_o), .buf_wdata_o(buf_wdata_o),
    .done_o(done_o), .err_o(err_o)
  );

  // sector buffer model, one cycle read latency
  logic [7:0] mem [512];
  logic [7:0] expm [512];
  int acc_cnt = 0;
  always @(posedge clk) begin
    if (buf_wr_o) mem[buf_addr_o] <= buf_wdata_o;
    if (buf_rd_o) buf_rdata_i <= mem[buf_addr_o];
    if (buf_rd_o || buf_wr_o) acc_cnt <= acc_cnt + 1;
  end

  int n_chk = 0, n_bad = 0;
  int unsigned seed = 32'h1234_5678;
  int locs [8];

  function automatic int unsigned nxt();
    seed = seed * 1103515245 + 12345;
    return seed >> 8;
  endfunction

  function automatic int plen_of(int m);
    return (m == 0) ? 52 : (m == 2) ? 208 : 104;
  endfunction

  function automatic int nsyn_of(int m);
    return (m == 0) ? 8 : (m == 2) ? 28 : 13;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 512; i++) begin
      mem[i]  = 8'((i * 29 + 7) ^ (i >> 3));
      expm[i] = 8'((i * 29 + 7) ^ (i >> 3));
    end
  endtask

  // one operation; kind 0 normal, 1 erased parity, 2 uncorrectable
  task automatic run_op(input int m, input int cnt, input int kind, input bit poke,
                        input string req);
    int pl, nv, ni, lat, a0, bad, nsy, ecnt, explat, firstbad;
    bit seen;
    pl = plen_of(m); nsy = nsyn_of(m);
    nv = 0; ni = 0;
    ecnt = (cnt > 8) ? 8 : cnt;
    if (kind == 0) begin
      for (int k = 0; k < ecnt; k++) begin
        if (locs[k] >= pl && locs[k] - pl < 4096) begin
          int d;
          d = locs[k] - pl;
          expm[511 - d / 8] ^= 8'(1 << (d % 8));
          nv++;
        end else ni++;
      end
    end
    @(negedge clk);
    mode_i = 2'(m); err_cnt_i = 4'(cnt);
    for (int k = 0; k < 8; k++) err_loc_i[k*13 +: 13] = 13'(locs[k]);
    par_i = {224{1'b1}};
    if (kind != 1) par_i[(nsy-1)*8 +: 8] = 8'h3C;
    par_i[nsy*8 +: 8] = 8'h00;  // byte past the checked range
    if (nsy == 28) par_i[0 +: 8] = (kind == 1) ? 8'hFF : 8'h00;
    uncorr_i = (kind == 2);
    start_i = 1'b1;
    a0 = acc_cnt;
    lat = 0; seen = 0;
    while (!seen && lat < 60) begin
      @(posedge clk); #1;
      lat++;
      if (done_o) seen = 1;
      @(negedge clk);
      start_i = poke && (lat == 3);
      uncorr_i = poke && (lat == 3);
    end
    start_i = 1'b0; uncorr_i = 1'b0;
    check(seen, "R9 done seen", lat, 0);
    explat = (kind != 0) ? 1 : 2 + 2 * nv + ni;
    check(lat == explat, {req, " R9 latency"}, lat, explat);
    check(err_o == (kind == 2), {req, " R7 status"}, err_o, kind == 2);
    @(posedge clk); #1;
    check(!done_o, "R9 done one cycle", done_o, 0);
    bad = 0; firstbad = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (firstbad < 0) firstbad = i;
      end
    check(bad == 0, {req, " R2 buffer bytes wrong, first at"}, firstbad, -1);
    check(acc_cnt - a0 == 2 * nv, {req, " R4 access count"}, acc_cnt - a0, 2 * nv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; uncorr_i = 0; mode_i = 0; err_cnt_i = 0;
    err_loc_i = '0; par_i = '0; calc_i = '0;
    fill_mem();
    repeat (3) @(posedge clk);
    #1;
    check(!done_o && !buf_rd_o && !buf_wr_o && !err_o, "reset state", done_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 syndrome reversal in every mode encoding
    for (int m = 0; m < 4; m++) begin
      int ns, bad;
      ns = nsyn_of(m); bad = 0;
      mode_i = 2'(m);
      for (int i = 0; i < 28; i++) calc_i[i*8 +: 8] = 8'(i * 37 + 5 + m);
      #1;
      for (int i = 0; i <= 28; i++) begin
        int e;
        e = (i < ns) ? ((ns - 1 - i) * 37 + 5 + m) % 256 : (i == ns) ? 255 : 0;
        if (syn_o[i*8 +: 8] !== 8'(e)) bad++;
      end
      check(bad == 0, "R5 syndrome order and terminator", bad, 0);
      @(negedge clk);
    end

    // R1 R2 R3 boundary locations, all modes
    for (int m = 0; m < 4; m++) begin
      int pl;
      pl = plen_of(m);
      locs[0] = pl - 1; locs[1] = pl; locs[2] = pl + 4095; locs[3] = pl + 4096;
      locs[4] = 0; locs[5] = pl + 7; locs[6] = pl + 8; locs[7] = 8191;
      run_op(m, 8, 0, 0, "R1 R3 boundary set");
    end

    // R8 repeated location toggles back; count 0; count above 8
    for (int k = 0; k < 8; k++) locs[k] = 300;
    run_op(1, 9, 0, 0, "R8 repeat and clamp");
    run_op(2, 0, 0, 0, "R8 zero count");
    locs[0] = 104 + 1000; locs[1] = 104 + 1001;
    run_op(1, 2, 0, 0, "R8 two in one byte");

    // R6 erased skip (also with uncorr high), R7 abort
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 8; k++) locs[k] = 500 + k;
      run_op(m, 8, 1, 0, "R6 erased skip");
      run_op(m, 8, 2, 0, "R7 uncorrectable abort");
    end

    // R9 start pulse while busy is ignored
    for (int k = 0; k < 8; k++) locs[k] = 210 + 13 * k;
    run_op(2, 8, 0, 1, "R9 busy start ignored");

    // pseudo-random sweep with frequent collisions
    for (int t = 0; t < 60; t++) begin
      int m, c;
      m = int'(nxt() % 4); c = int'(nxt() % 10);
      for (int k = 0; k < 8; k++) locs[k] = int'(nxt() % (plen_of(m) + 4120));
      if (t % 5 == 0) for (int k = 1; k < 8; k++) locs[k] = locs[0] + k % 3;
      run_op(m, c, 0, 0, "R2 random sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule